// File: doc/BRIEF.md
# CAS-Latency Burst Read Output Pipeline

This block sits between the command decoder of a synchronous read-only memory and its data pins. The decoder presents Read, Row Active, Stop and mask strobes together with the current mode settings. The block schedules each burst a programmable CAS latency after its Read command. It walks the burst column order, looks up each word in a synchronous array model, and drives a 32-bit data bus with separate output enables for the low and high 16-bit lanes.

A Read carries its own width select. In the narrow (x16) mode only the low lane is driven. In the wide (x32) mode both lanes are driven. A read issued late enough after the previous one chains onto it without an idle cycle. A read issued too early discards the older request. Stop commands and the data mask act after fixed delays. While the internal clock enable is low, the whole pipeline freezes.

The array model returns a word that is a fixed function of its address, so every beat can be predicted.

Top module: `burst_out_pipe`

## Requirements
- R1: With `cfg_lat` = L (only 4, 5 or 6 are supported), a Read sampled at enabled edge T places its first beat on the bus from edge T+L-1, so it is sampled at edge T+L. The output enable turns on at that same edge T+L-1.
- R2: `cfg_len8` = 0 gives 4 beats and 1 gives 8 beats, on consecutive enabled edges. After the last beat both enables return to 0, unless a newer burst takes over the bus.
- R3: The starting column is `rd_col`. For a burst of length 4, bits 1:0 vary; for length 8, bits 2:0 vary. The upper column bits are held. With `cfg_ilv` = 0 the varying bits of beat k are (start + k) modulo the length. With `cfg_ilv` = 1 they are start XOR k.
- R4: With `rd_wide` = 1, column bit 8 is ignored. Bits 15:0 carry word({row, c[7:0], 0}), bits 31:16 carry word({row, c[7:0], 1}), and both enables are on. With `rd_wide` = 0, bits 15:0 carry word({row, c}) and `dq_oe_hi` stays 0.
- R5: The array word at the 13-bit address a = {row[3:0], col[8:0]} is a zero-extended to 16 bits, XOR 16'hC35A. The row is the one latched by the last Row Active (`act_req`) before the Read.
- R6: A Read sampled L-1 or more enabled edges after the previous Read lets the older burst run until the new burst's first beat. The new burst follows with no idle cycle and replaces the rest of the older burst.
- R7: A Read or Row Active sampled fewer than L-1 enabled edges after a Read cancels that earlier Read, so none of its beats appear. A replacing Read still starts on its own schedule.
- R8: A stop strobe (`stop_req`, used for both Burst Stop and Precharge) sampled at enabled edge S removes every beat that would be on the bus from edge S+L-1 onward. The enables go to 0 at that edge.
- R9: `mask_in` sampled high at enabled edge M turns off both enables for the beat loaded at the next enabled edge. That beat is the one sampled two edges after M. The beat order is not changed.
- R10: While `clk_en` is 0, all outputs and the internal state hold their values, and every command and mask input is ignored.
- R11: After reset both enables are 0 and the latched row is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Internal clock enable; low freezes the block |
| act_req | input | 1 | Row Active strobe |
| act_row | input | 4 | Row to latch on Row Active |
| rd_req | input | 1 | Read strobe |
| rd_wide | input | 1 | 1 = x32 read, 0 = x16 read |
| rd_col | input | 9 | Starting column of the read |
| stop_req | input | 1 | Burst Stop / Precharge strobe |
| mask_in | input | 1 | Output mask strobe |
| cfg_lat | input | 3 | CAS latency (4, 5, 6) |
| cfg_len8 | input | 1 | Burst length 8 when 1, else 4 |
| cfg_ilv | input | 1 | Interleaved order when 1, else sequential |
| dq_out | output | 32 | Data bus value |
| dq_oe_lo | output | 1 | Enable for bits 15:0 |
| dq_oe_hi | output | 1 | Enable for bits 31:16 |

## Verification
The critical coincidence is a chained Read that arrives on exactly the edge where the older pending Read launches its first beat. On that edge the launch and the capture of the new request happen together. The bench provokes this at latency 6 and at latency 4, where a length-8 burst is followed by a length-4 burst. The bench's model overwrites the older burst's remaining beats from the new start edge onward. Every edge is then compared, so a dropped launch, a gap, or a leftover older beat shows up as a mismatch on a named beat.

// File: rtl/burst_out_pipe.sv
module burst_out_pipe #(
  parameter int ROW_W = 4,
  parameter int COL_W = 9,
  parameter logic [15:0] SEED = 16'hC35A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             act_req,
  input  logic [ROW_W-1:0] act_row,
  input  logic             rd_req,
  input  logic             rd_wide,
  input  logic [COL_W-1:0] rd_col,
  input  logic             stop_req,
  input  logic             mask_in,
  input  logic [2:0]       cfg_lat,
  input  logic             cfg_len8,
  input  logic             cfg_ilv,
  output logic [31:0]      dq_out,
  output logic             dq_oe_lo,
  output logic             dq_oe_hi
);

  function automatic logic [15:0] word_at(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    logic [ROW_W+COL_W-1:0] a;
    a = {r, c};
    return 16'(a) ^ SEED;
  endfunction

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] c, input logic len8,
                                                input logic ilv, input logic [3:0] k);
    logic [2:0] lo;
    lo = ilv ? (c[2:0] ^ k[2:0]) : (c[2:0] + k[2:0]);
    return len8 ? {c[COL_W-1:3], lo} : {c[COL_W-1:2], lo[1:0]};
  endfunction

  logic [ROW_W-1:0] row_q, pend_row, b_row, s_row;
  logic [COL_W-1:0] pend_col, b_col, s_col, bc;
  logic             pend_v, pend_wide, pend_len8, pend_ilv;
  logic [2:0]       pend_cnt, stop_cnt;
  logic             stop_v, run, mask_q;
  logic             b_wide, b_len8, b_ilv;
  logic             s_wide, s_len8, s_ilv;
  logic [3:0]       b_idx, s_k;
  logic             start, kill, emit;
  logic [31:0]      nxt_data, dq_q;
  logic             oe_lo_q, oe_hi_q;

  assign start  = pend_v && (pend_cnt == 3'd0);
  assign kill   = stop_v && (stop_cnt == 3'd0);
  assign s_col  = start ? pend_col  : b_col;
  assign s_row  = start ? pend_row  : b_row;
  assign s_wide = start ? pend_wide : b_wide;
  assign s_len8 = start ? pend_len8 : b_len8;
  assign s_ilv  = start ? pend_ilv  : b_ilv;
  assign s_k    = start ? 4'd0 : b_idx;
  assign emit   = start || (run && !kill && (b_idx < (b_len8 ? 4'd8 : 4'd4)));
  assign bc     = beat_col(s_col, s_len8, s_ilv, s_k);
  assign nxt_data = s_wide ? {word_at(s_row, {bc[COL_W-2:0], 1'b1}), word_at(s_row, {bc[COL_W-2:0], 1'b0})}
                           : {16'h0000, word_at(s_row, bc)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0; pend_row <= '0; pend_col <= '0; pend_v <= 1'b0;
      pend_wide <= 1'b0; pend_len8 <= 1'b0; pend_ilv <= 1'b0; pend_cnt <= '0;
      stop_v <= 1'b0; stop_cnt <= '0; run <= 1'b0; mask_q <= 1'b0;
      b_row <= '0; b_col <= '0; b_wide <= 1'b0; b_len8 <= 1'b0; b_ilv <= 1'b0; b_idx <= '0;
      dq_q <= '0; oe_lo_q <= 1'b0; oe_hi_q <= 1'b0;
    end else if (clk_en) begin
      mask_q <= mask_in;
      if (act_req) row_q <= act_row;

      if (rd_req) begin
        pend_v    <= 1'b1;
        pend_cnt  <= cfg_lat - 3'd2;
        pend_col  <= rd_col;
        pend_row  <= row_q;
        pend_wide <= rd_wide;
        pend_len8 <= cfg_len8;
        pend_ilv  <= cfg_ilv;
      end else if (act_req || start) begin
        pend_v <= 1'b0;
      end else if (pend_v) begin
        pend_cnt <= pend_cnt - 3'd1;
      end

      if (stop_req) begin
        stop_v   <= 1'b1;
        stop_cnt <= cfg_lat - 3'd2;
      end else if (kill) begin
        stop_v <= 1'b0;
      end else if (stop_v) begin
        stop_cnt <= stop_cnt - 3'd1;
      end

      if (start) begin
        b_row <= pend_row; b_col <= pend_col; b_wide <= pend_wide;
        b_len8 <= pend_len8; b_ilv <= pend_ilv; b_idx <= 4'd1;
      end else if (run) begin
        b_idx <= b_idx + 4'd1;
      end
      run <= emit;

      dq_q    <= nxt_data;
      oe_lo_q <= emit && !mask_q;
      oe_hi_q <= emit && !mask_q && s_wide;
    end
  end

  assign dq_out   = dq_q;
  assign dq_oe_lo = oe_lo_q;
  assign dq_oe_hi = oe_hi_q;

endmodule

module burst_out_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clk_en,
  input logic        mask_in,
  input logic [31:0] dq_out,
  input logic        dq_oe_lo,
  input logic        dq_oe_hi
);
  // R10
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(dq_out) && $stable(dq_oe_lo) && $stable(dq_oe_hi)));

  // R9
  mask_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_in && clk_en) ##1 clk_en |=> (!dq_oe_lo && !dq_oe_hi));

  // R4
  lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_hi |-> dq_oe_lo);

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dq_oe_lo && !dq_oe_hi));
endmodule

bind burst_out_pipe burst_out_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .mask_in(mask_in),
  .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi)
);

// File: tb/burst_out_pipe_test.sv
module burst_out_pipe_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1;
  logic act_req = 1'b0;
  logic [3:0] act_row = '0;
  logic rd_req = 1'b0;
  logic rd_wide = 1'b0;
  logic [8:0] rd_col = '0;
  logic stop_req = 1'b0;
  logic mask_in = 1'b0;
  logic [2:0] cfg_lat = 3'd5;
  logic cfg_len8 = 1'b0;
  logic cfg_ilv = 1'b0;
  logic [31:0] dq_out;
  logic dq_oe_lo, dq_oe_hi;

  always #4 clk = ~clk;

  burst_out_pipe uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .act_req(act_req), .act_row(act_row),
    .rd_req(rd_req), .rd_wide(rd_wide), .rd_col(rd_col), .stop_req(stop_req),
    .mask_in(mask_in), .cfg_lat(cfg_lat), .cfg_len8(cfg_len8), .cfg_ilv(cfg_ilv),
    .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi)
  );

  typedef struct { bit lo; bit hi; logic [31:0] d; string tag; } exp_t;
  exp_t  sb[int];
  bit    mk[int];
  int    e = 0;
  int    ncmp = 0;
  int    nerr = 0;
  int    row_m = 0;
  bit    pend_ok = 0;
  int    pend_start = 0;
  string cur_tag = "R1";
  bit    done = 0;

  function automatic logic [15:0] mw(int r, int c);
    return 16'((r << 9) | c) ^ 16'hC35A;
  endfunction

  function automatic int bcol(int c, bit len8, bit ilv, int k);
    int m = len8 ? 7 : 3;
    int lo = ilv ? ((c & m) ^ k) & m : ((c & m) + k) & m;
    return (c & ~m) | lo;
  endfunction

  task automatic clear_from(int s);
    for (int i = s; i < s + 16; i++) if (sb.exists(i)) sb.delete(i);
  endtask

  task automatic model_read(int t);
    int cl = int'(cfg_lat);
    int bl = cfg_len8 ? 8 : 4;
    if (pend_ok && t < pend_start) clear_from(pend_start);
    clear_from(t + cl - 1);
    for (int k = 0; k < bl; k++) begin
      int c = bcol(int'(rd_col), cfg_len8, cfg_ilv, k);
      exp_t x;
      if (rd_wide) begin
        int c8 = c & 255;
        x.d = {mw(row_m, c8 * 2 + 1), mw(row_m, c8 * 2)};
      end else begin
        x.d = {16'h0000, mw(row_m, c)};
      end
      x.lo = 1'b1; x.hi = rd_wide; x.tag = cur_tag;
      sb[t + cl - 1 + k] = x;
    end
    pend_ok = 1; pend_start = t + cl - 1;
  endtask

  task automatic model_act(int t);
    if (pend_ok && t < pend_start) clear_from(pend_start);
    pend_ok = 0;
    row_m = int'(act_row);
  endtask

  task automatic compare();
    bit el = 0, eh = 0, bad = 0;
    logic [31:0] ed = '0;
    string tg = "R2";
    if (sb.exists(e)) begin
      el = sb[e].lo && !mk.exists(e);
      eh = sb[e].hi && !mk.exists(e);
      ed = sb[e].d; tg = sb[e].tag;
      if (mk.exists(e)) tg = {tg, "/R9"};
    end
    ncmp++;
    if (dq_oe_lo !== el || dq_oe_hi !== eh) bad = 1;
    if (el && dq_out[15:0] !== ed[15:0]) bad = 1;
    if (eh && dq_out[31:16] !== ed[31:16]) bad = 1;
    if (bad) begin
      nerr++;
      $display("FAIL %s edge %0d: actual oe=%b%b dq=%h expected oe=%b%b dq=%h",
               tg, e, dq_oe_hi, dq_oe_lo, dq_out, eh, el, ed);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (clk_en) begin
      e++;
      if (rd_req) model_read(e);
      if (act_req) model_act(e);
      if (stop_req) clear_from(e + int'(cfg_lat) - 1);
      if (mask_in) mk[e + 1] = 1;
    end
    #2;
    compare();
    rd_req = 0; act_req = 0; stop_req = 0; mask_in = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rd(int col, bit wide);
    rd_col = 9'(col); rd_wide = wide; rd_req = 1; step();
  endtask

  task automatic act(int r);
    act_row = 4'(r); act_req = 1; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    ncmp++;
    if (dq_oe_lo !== 1'b0 || dq_oe_hi !== 1'b0) begin
      nerr++;
      $display("FAIL R11 in reset: actual oe=%b%b expected oe=00", dq_oe_hi, dq_oe_lo);
    end
    rst_n = 1;
    idle(2);

    cur_tag = "R1/R3/R5/R11";   // row 0 after reset, seq len4 x16, CL5
    rd(9'h0F6, 0); idle(10);

    cur_tag = "R2/R3/R4/R5";    // CL4, interleaved len8 x32, row 3
    act(3); idle(1);
    cfg_lat = 3'd4; cfg_len8 = 1; cfg_ilv = 1;
    rd(9'h135, 1); idle(14);

    cur_tag = "R6";             // chained read exactly CL-1 later at CL6
    cfg_lat = 3'd6; cfg_len8 = 1; cfg_ilv = 0;
    rd(9'h1F0, 0); idle(4);
    cfg_len8 = 0;
    rd(9'h04A, 1); idle(14);
    cfg_lat = 3'd4; cfg_len8 = 1;   // R6 at CL4, len8 then len4
    rd(9'h013, 0); idle(2);
    cfg_len8 = 0;
    rd(9'h0A2, 0); idle(12);
    cfg_len8 = 1; cfg_lat = 3'd5;   // R6 chained two edges beyond CL-1
    rd(9'h060, 1); idle(5);
    rd(9'h0C4, 0); idle(14);

    cur_tag = "R7";             // early read cancels older read, CL5
    cfg_len8 = 0;
    rd(9'h0AA, 0); idle(1);
    rd(9'h155, 0); idle(12);
    rd(9'h0EE, 1);              // Row Active one edge later cancels it
    act(5); idle(12);
    rd(9'h009, 0); idle(10);

    cur_tag = "R8";             // stop truncates a len8 burst
    cfg_len8 = 1;
    rd(9'h038, 1); idle(5);
    stop_req = 1; step(); idle(12);
    cfg_lat = 3'd6;
    rd(9'h101, 0); idle(6);
    stop_req = 1; step(); idle(14);

    cur_tag = "R9";             // mask two edges ahead
    cfg_lat = 3'd4;
    rd(9'h07C, 1); idle(3);
    mask_in = 1; step(); idle(1);
    mask_in = 1; step();
    mask_in = 1; step(); idle(12);

    cur_tag = "R10";            // suspend mid-burst, commands ignored
    cfg_lat = 3'd5; cfg_ilv = 1;
    rd(9'h0B3, 0); idle(5);
    clk_en = 0;
    idle(1);
    rd(9'h1FF, 1);
    mask_in = 1; step();
    stop_req = 1; step();
    clk_en = 1;
    idle(14);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end
endmodule